// File: doc/BRIEF.md
# Prescaled 64-bit Tick Timer

This block is a free-running 64-bit up-counter that software reaches through a small 32-bit register port. An integer divider sets the counter's pace. A field in the control word picks how many input clocks make up one count. Changing that field leaves the running count untouched, so software can retune the divider when the input clock rate moves and keep the count's timebase steady.

A 64-bit comparator watches the count. When the comparator is armed and the count steps onto the programmed value, an event flag is raised. The flag can drive the interrupt pin. In periodic mode, each event adds a programmable step to the comparator, so events keep firing at a fixed spacing with no help from software. Software clears the flag by writing a one to it. Reading the low count word also captures the high word, so software always gets a torn-free 64-bit value.

The register port is a plain single-cycle strobe and uses no handshake. A read returns its data in the cycle after the strobe. A write takes effect at the strobe's clock edge.

Top module: `tick_timer64`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and the counter does not move. The counter holds its value whenever the run bit (control bit 0) is clear.
- R2: With the run bit set, the counter advances once every P+1 clocks, where P is the divider field in control bits 15:8. P=0 counts every clock.
- R3: Each count adds exactly one to the full 64-bit value, with carry from the low word (offset 0x00) into the high word (offset 0x04).
- R4: Writing the control word (offset 0x08) sets the divider and the four mode bits exactly as written and reads back the same. It never alters the counter value.
- R5: A read of the high count word returns the high half as it stood when the low word was last read.
- R6: The event flag (status offset 0x0C, bit 0) is set on the count step that makes the counter equal to the comparator (low 0x10, high 0x14), but only while the compare-enable bit (control bit 1) is set.
- R7: `irq` is high exactly when the event flag is set and the interrupt-enable bit (control bit 2) is set.
- R8: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear has no effect. A new event in the same cycle as a clear leaves the flag set.
- R9: With the periodic bit (control bit 3) set, every event adds the step register (offset 0x18, zero-extended) to the comparator.
- R10: A software write to a counter or comparator word wins over the count step or periodic update in the same cycle. A cycle in which the counter is written raises no event.
- R11: A read strobe returns the addressed register in the next cycle. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read (qualified by `reg_sel`) |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt request, level |

## Verification
The divider-spacing assertion assumes the divider field stays unchanged across the cycle after a count. The periodic-reload assertion assumes no comparator write lands in the same cycle as an event. Both are checked only under those conditions, so a retune or an overriding write is still legal stimulus. The random phase keeps the divider small and places comparator and counter writes a few counts ahead of the live count, so events, periodic reloads and write-versus-update collisions all happen often. Reads cover every offset, including the unmapped one.

// File: rtl/tt64_pkg.sv
package tt64_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned PRESC_LSB = 8;
  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_CMP    = 1;
  localparam int unsigned CB_IRQ    = 2;
  localparam int unsigned CB_AUTO   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 5'h00,
    A_CNT_HI = 5'h04,
    A_CTRL   = 5'h08,
    A_STAT   = 5'h0C,
    A_CMP_LO = 5'h10,
    A_CMP_HI = 5'h14,
    A_STEP   = 5'h18
  } tt_addr_e;
endpackage

// File: rtl/tt64_prescale.sv
module tt64_prescale #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] div_q;

  assign tick = run && (div_q >= presc);

  always_ff @(posedge clk) begin
    if (!rst_n)     div_q <= '0;
    else if (!run)  div_q <= '0;
    else if (tick)  div_q <= '0;
    else            div_q <= div_q + PRESC_W'(1);
  end

  // R2: with a nonzero, unchanged divider two counts never come back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0) ##1 $stable(presc) |-> !tick);
endmodule

// File: rtl/tt64_counter.sv
module tt64_counter #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] cnt
);
  localparam int CNT_W = 2 * DATA_W;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt = cnt_q;

  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_q[DATA_W-1:0] == $past(wdata));
endmodule

// File: rtl/tt64_compare.sv
module tt64_compare #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                cnt_wr,
  input  logic [2*DATA_W-1:0] cnt,
  input  logic                cmp_en,
  input  logic                auto_rl,
  input  logic [STEP_W-1:0]   step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                clr,
  output logic [2*DATA_W-1:0] cmp,
  output logic                flag,
  output logic                hit
);
  localparam int CNT_W = 2 * DATA_W;
  logic [CNT_W-1:0] cmp_q, cnt_nx, step_ext;
  logic             flag_q;

  assign cnt_nx   = cnt + CNT_W'(1);
  assign step_ext = CNT_W'(step);
  assign hit      = tick && !cnt_wr && cmp_en && (cnt_nx == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cmp_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) cmp_q[CNT_W-1:DATA_W] <= wdata;
    end else if (hit && auto_rl) begin
      cmp_q <= cmp_q + step_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign cmp  = cmp_q;
  assign flag = flag_q;

  assert_flag_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cmp_en) && $past(tick));

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q);

  assert_periodic_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_rl && !wr_lo && !wr_hi) |=> cmp_q == $past(cmp_q) + $past(step_ext));
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64 #(
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 8,
  parameter int STEP_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_sel,
  input  logic                      reg_write,
  input  logic [tt64_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic                      irq
);
  import tt64_pkg::*;
  localparam int CNT_W = 2 * DATA_W;

  logic wr, rd;
  logic run_q, cmp_en_q, irq_en_q, auto_q;
  logic [PRESC_W-1:0] presc_q;
  logic [STEP_W-1:0]  step_q;
  logic [DATA_W-1:0]  shadow_q, rdata_q, rd_val;
  logic [CNT_W-1:0]   cnt, cmp;
  logic tick, flag, hit;
  logic w_cnt_lo, w_cnt_hi, w_cmp_lo, w_cmp_hi, w_ctrl, w_stat, w_step;

  assign wr       = reg_sel && reg_write;
  assign rd       = reg_sel && !reg_write;
  assign w_cnt_lo = wr && (reg_addr == A_CNT_LO);
  assign w_cnt_hi = wr && (reg_addr == A_CNT_HI);
  assign w_ctrl   = wr && (reg_addr == A_CTRL);
  assign w_stat   = wr && (reg_addr == A_STAT);
  assign w_cmp_lo = wr && (reg_addr == A_CMP_LO);
  assign w_cmp_hi = wr && (reg_addr == A_CMP_HI);
  assign w_step   = wr && (reg_addr == A_STEP);

  tt64_prescale #(.PRESC_W(PRESC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run_q), .presc(presc_q), .tick(tick));

  tt64_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(w_cnt_lo), .wr_hi(w_cnt_hi),
    .wdata(reg_wdata), .cnt(cnt));

  tt64_compare #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(w_cnt_lo || w_cnt_hi),
    .cnt(cnt), .cmp_en(cmp_en_q), .auto_rl(auto_q), .step(step_q),
    .wr_lo(w_cmp_lo), .wr_hi(w_cmp_hi), .wdata(reg_wdata),
    .clr(w_stat && reg_wdata[0]), .cmp(cmp), .flag(flag), .hit(hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; cmp_en_q <= 1'b0; irq_en_q <= 1'b0; auto_q <= 1'b0;
      presc_q <= '0; step_q <= '0;
    end else begin
      if (w_ctrl) begin
        run_q    <= reg_wdata[CB_RUN];
        cmp_en_q <= reg_wdata[CB_CMP];
        irq_en_q <= reg_wdata[CB_IRQ];
        auto_q   <= reg_wdata[CB_AUTO];
        presc_q  <= reg_wdata[PRESC_LSB +: PRESC_W];
      end
      if (w_step) step_q <= reg_wdata[STEP_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      A_CNT_LO: rd_val = cnt[DATA_W-1:0];
      A_CNT_HI: rd_val = shadow_q;
      A_CTRL: begin
        rd_val[CB_RUN]  = run_q;
        rd_val[CB_CMP]  = cmp_en_q;
        rd_val[CB_IRQ]  = irq_en_q;
        rd_val[CB_AUTO] = auto_q;
        rd_val[PRESC_LSB +: PRESC_W] = presc_q;
      end
      A_STAT:   rd_val[0] = flag;
      A_CMP_LO: rd_val = cmp[DATA_W-1:0];
      A_CMP_HI: rd_val = cmp[CNT_W-1:DATA_W];
      A_STEP:   rd_val = DATA_W'(step_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else if (rd) begin
      rdata_q <= rd_val;
      if (reg_addr == A_CNT_LO) shadow_q <= cnt[CNT_W-1:DATA_W];
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = flag && irq_en_q;

  assert_shadow_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && reg_addr == A_CNT_LO) |=> shadow_q == $past(cnt[CNT_W-1:DATA_W]));

  assert_ctrl_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && !tick) |=> $stable(cnt));
endmodule

// File: tb/sim_tick_timer64.sv
module sim_tick_timer64;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_write = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0, bad = 0;
  logic pend_rd = 1'b0;

  // bench model state
  logic [7:0]  m_div;
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_step, m_shadow, m_rdata;
  logic [15:0] m_ctrl;
  logic        m_flag, m_tk, m_hit, m_cw;

  always #(CYC/2) clk = ~clk;

  tick_timer64 u0 (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return m_cnt[31:0];
      5'h04: return m_shadow;
      5'h08: return {16'h0, m_ctrl};
      5'h0C: return {31'h0, m_flag};
      5'h10: return m_cmp[31:0];
      5'h14: return m_cmp[63:32];
      5'h18: return m_step;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_cmp = 0; m_step = 0; m_shadow = 0; m_rdata = 0;
      m_ctrl = 0; m_flag = 0;
    end else begin
      m_tk  = m_ctrl[0] && (m_div >= m_ctrl[15:8]);
      m_cw  = reg_sel && reg_write && (reg_addr == 5'h00 || reg_addr == 5'h04);
      m_hit = m_tk && !m_cw && m_ctrl[1] && (m_cnt + 64'd1 == m_cmp);
      if (reg_sel && !reg_write) begin
        m_rdata = model_read(reg_addr);
        if (reg_addr == 5'h00) m_shadow = m_cnt[63:32];
      end
      m_div = !m_ctrl[0] ? 8'd0 : (m_tk ? 8'd0 : m_div + 8'd1);
      if (m_cw) begin
        if (reg_addr == 5'h00) m_cnt[31:0]  = reg_wdata;
        if (reg_addr == 5'h04) m_cnt[63:32] = reg_wdata;
      end else if (m_tk) m_cnt = m_cnt + 64'd1;
      if (reg_sel && reg_write && reg_addr == 5'h10) m_cmp[31:0] = reg_wdata;
      else if (reg_sel && reg_write && reg_addr == 5'h14) m_cmp[63:32] = reg_wdata;
      else if (m_hit && m_ctrl[3]) m_cmp = m_cmp + {32'h0, m_step};
      if (m_hit) m_flag = 1'b1;
      else if (reg_sel && reg_write && reg_addr == 5'h0C && reg_wdata[0]) m_flag = 1'b0;
      if (reg_sel && reg_write && reg_addr == 5'h08) m_ctrl = {reg_wdata[15:8], 4'h0, reg_wdata[3:0]};
      if (reg_sel && reg_write && reg_addr == 5'h18) m_step = reg_wdata;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    if (pend_rd) chk("R11 read data vs model", reg_rdata, m_rdata);
    chk("R7 irq vs model", irq, m_flag && m_ctrl[2]);
    pend_rd = s && !w;
    reg_sel = s; reg_write = w; reg_addr = a; reg_wdata = d;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    drive(1'b1, 1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 5'h0, 32'h0);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    drive(1'b1, 1'b0, a, 32'h0);
    idle(1);
    v = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    reg_sel = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0; pend_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CYC * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v1, v2;
    void'($urandom(32'h1357_2468));
    do_reset();

    // R1: reset state
    for (int i = 0; i < 7; i++) begin
      rd(5'(i * 4), v);
      chk("R1 reset register value", v, 0);
    end
    chk("R1 irq low after reset", irq, 0);
    idle(10);
    rd(5'h00, v);
    chk("R1 counter stopped", v, 0);

    // R2/R3: divider 0, 20 capture edges apart
    wr(5'h08, 32'h1);
    idle(3);
    rd(5'h00, v1); idle(18); rd(5'h00, v2);
    chk("R2 divide by 1 count delta", v2 - v1, 20);
    // R2: divider 3, 40 edges -> 10 counts
    wr(5'h08, 32'h301);
    idle(5);
    rd(5'h00, v1); idle(38); rd(5'h00, v2);
    chk("R2 divide by 4 count delta", v2 - v1, 10);

    // R4: retuning divider keeps count and other bits
    wr(5'h08, 32'h300);
    rd(5'h00, v1);
    wr(5'h08, 32'h506);
    rd(5'h00, v2);
    chk("R4 count unchanged by divider write", v2, v1);
    rd(5'h08, v);
    chk("R4 control readback", v, 32'h506);

    // R5/R3: torn-free read and carry
    wr(5'h08, 32'h0); wr(5'h00, 32'hFFFF_FFF0); wr(5'h04, 32'h0); wr(5'h08, 32'h1);
    rd(5'h00, v1); idle(40); rd(5'h04, v);
    chk("R5 high word from snapshot", v, 0);
    rd(5'h00, v1); rd(5'h04, v);
    chk("R3 carry into high word", v, 1);

    // R6/R7: one-shot event
    wr(5'h08, 32'h0); wr(5'h0C, 32'h1);
    wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h10, 32'd30); wr(5'h14, 32'h0);
    wr(5'h08, 32'h7);
    idle(5);
    chk("R6 no event before match", irq, 0);
    idle(40);
    chk("R7 irq after match", irq, 1);
    rd(5'h0C, v);
    chk("R6 flag set on match", v, 1);

    // R8: clear semantics
    wr(5'h0C, 32'h0); rd(5'h0C, v);
    chk("R8 write zero keeps flag", v, 1);
    wr(5'h0C, 32'h1); idle(1);
    chk("R8 irq dropped by clear", irq, 0);
    rd(5'h0C, v);
    chk("R8 flag cleared", v, 0);
    idle(50);
    chk("R6 one-shot does not repeat", irq, 0);

    // R7 gating by interrupt enable
    wr(5'h08, 32'h0); wr(5'h00, 32'h0); wr(5'h10, 32'd10); wr(5'h08, 32'h3);
    idle(20);
    chk("R7 irq masked", irq, 0);
    rd(5'h0C, v);
    chk("R6 flag set while masked", v, 1);
    wr(5'h08, 32'h7); idle(1);
    chk("R7 irq after unmask", irq, 1);

    // R9: periodic reload
    wr(5'h0C, 32'h1); wr(5'h08, 32'h0); wr(5'h00, 32'h0);
    wr(5'h10, 32'd10); wr(5'h18, 32'd1000); wr(5'h08, 32'hF);
    idle(30);
    rd(5'h10, v);
    chk("R9 comparator advanced by step", v, 32'd1010);
    chk("R9 irq after periodic event", irq, 1);

    // R10: write precedence and no event on written match
    wr(5'h00, 32'h100); rd(5'h00, v);
    chk("R10 counter write wins over count", v, 32'h100);
    wr(5'h0C, 32'h1); wr(5'h10, 32'h2000); wr(5'h00, 32'h2000);
    idle(5);
    rd(5'h0C, v);
    chk("R10 no event from counter write", v, 0);

    // random phase against the bench model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 11);
      case (r)
        0: wr(5'h08, {16'h0, 8'($urandom_range(0, 2)), 4'h0, 4'($urandom_range(0, 15))});
        1: wr(5'h10, m_cnt[31:0] + $urandom_range(1, 40));
        2: wr(5'h14, m_cnt[63:32]);
        3: wr(5'h18, $urandom_range(3, 30));
        4: wr(5'h0C, $urandom_range(0, 1));
        5: wr(5'h00, m_cnt[31:0] + $urandom_range(0, 20));
        6: idle($urandom_range(1, 8));
        default: drive(1'b1, 1'b0, 5'($urandom_range(0, 7) * 4), 32'h0);
      endcase
    end
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule